// File: doc/BRIEF.md
# OSD Dot Colour and Blink Output Stage

This block sits at the end of an on-screen display pipeline. For every dot clock it takes the font bit of the current character cell together with that cell's attributes: a foreground colour, a background colour for the word it belongs to, and a blink flag. From these it drives the red, green and blue display outputs and the fast-blanking output, which switches the screen from the video source to the overlay. Attributes are captured only at a character boundary, so a cell keeps one colour set from its first dot to its last.

A blink timer counts vertical sync rising edges. A rate code picks the blink period, which is 16, 32, 64 or 128 fields and applies to the whole frame. A ratio code picks the share of that period during which blinking characters are visible. During the dark share, the foreground dots of blinking characters are suppressed while their background is still drawn. Each output has its own active-level control. The same vertical sync edge can raise an interrupt request. The request stays pending until the CPU writes a clear.

Top module: `osd_color_out`

## Requirements
- R1: While `rst` is high and on the first cycle after it, each of `r_o`, `g_o`, `b_o` and `fb_o` sits at its inactive level (equal to its polarity bit), and `irq_o` is 0.
- R2: A dot is in the display area with its font bit set, and its character is not in a blink-dark phase. Raw R/G/B then equal the latched foreground code (bit 2 = R, bit 1 = G, bit 0 = B), and raw FB is 1.
- R3: A dot is in the display area but shows no foreground. With `box_mode_i` = 1, raw R/G/B equal the latched background code and raw FB is 1. With `box_mode_i` = 0, raw R/G/B and FB are all 0.
- R4: When `active_i` is 0, raw R/G/B and FB are all 0, whatever the font bit and mode.
- R5: `pol_i` bit 3 inverts R, bit 2 inverts G, bit 1 inverts B and bit 0 inverts FB. An output equals raw XOR its polarity bit.
- R6: Foreground, background and blink attributes are captured only on a cycle where `cell_start_i` = 1. Attribute changes on other cycles do not affect the outputs.
- R7: The blink phase counter advances by one on each rising edge of `vsync_i`. Rate code 0, 1, 2 or 3 gives a blink period of 16, 32, 64 or 128 vertical syncs. The phase is the count of edges since reset, modulo the period P.
- R8: Ratio code 0 and code 3 are dark for phases P/2 to P-1. Code 1 (on 1 : off 3) is dark for phases P/4 to P-1. Code 2 (on 3 : off 1) is dark for phases 3P/4 to P-1. In the dark share, a blinking character's font dots are treated as background dots. Characters without the blink flag are unaffected.
- R9: A rising edge of `vsync_i` sets `irq_o` on the following clock only when `irq_en_i` = 1. With `irq_en_i` = 0 the edge leaves `irq_o` unchanged.
- R10: `irq_o` stays set until a cycle with `irq_clr_i` = 1 clears it. A set and a clear in the same cycle leave it set.
- R11: The outputs reflect the dot, display-area and attribute inputs sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Vertical sync, active high |
| dot_i | input | 1 | Font bit of the current dot |
| active_i | input | 1 | Dot lies inside the display area |
| cell_start_i | input | 1 | First dot of a character cell; captures attributes |
| fg_i | input | 3 | Foreground colour of the character {R,G,B} |
| bg_i | input | 3 | Background colour of the word {R,G,B} |
| blink_i | input | 1 | Character is a blinking one |
| box_mode_i | input | 1 | 1 = box background, 0 = no background |
| blink_rate_i | input | 2 | Blink period select (16/32/64/128 syncs) |
| blink_ratio_i | input | 2 | Blink on:off share select |
| pol_i | input | 4 | Active-level inversion {R,G,B,FB} |
| irq_en_i | input | 1 | Vertical sync interrupt enable |
| irq_clr_i | input | 1 | Clear pending interrupt |
| r_o | output | 1 | Red output |
| g_o | output | 1 | Green output |
| b_o | output | 1 | Blue output |
| fb_o | output | 1 | Fast-blanking output |
| irq_o | output | 1 | Vertical sync interrupt request |

## Verification
The bench uses the default parameters: a base blink period of 16 syncs and four rate steps, which gives a 7-bit phase counter. The shortest period therefore takes only 16 sync pulses to complete, so several full periods at rates 0 and 1 fit in a short run. More than 128 pulses in total also carry the counter through its wrap at the longest period. Under these values every dark-share boundary of every ratio code lands on an exact pulse count that the bench can predict.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int COL_W = 3;

  typedef struct packed {
    logic [COL_W-1:0] fg;
    logic [COL_W-1:0] bg;
    logic             blink;
  } cell_attr_t;

  typedef enum logic [1:0] {
    RATIO_EVEN   = 2'd0,
    RATIO_SHORT  = 2'd1,
    RATIO_LONG   = 2'd2,
    RATIO_EVEN_B = 2'd3
  } blink_ratio_e;
endpackage

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter int BASE_LOG   = 4,
  parameter int RATE_STEPS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          vsync_i,
  input  logic [$clog2(RATE_STEPS)-1:0] rate_i,
  input  logic [1:0]                    ratio_i,
  output logic                          vs_rise_o,
  output logic                          dark_o
);
  import osd_pkg::*;
  localparam int CNT_W = BASE_LOG + RATE_STEPS - 1;

  logic             vs_q;
  logic [CNT_W-1:0] phase_cnt;
  logic [1:0]       quarter;

  assign vs_rise_o = vsync_i & ~vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q      <= 1'b0;
      phase_cnt <= '0;
    end else begin
      vs_q <= vsync_i;
      if (vs_rise_o) phase_cnt <= phase_cnt + 1'b1;
    end
  end

  // the two top bits of the phase inside the selected period
  always_comb begin
    quarter = phase_cnt[BASE_LOG-1 -: 2];
    for (int r = 0; r < RATE_STEPS; r++)
      if (rate_i == r[$clog2(RATE_STEPS)-1:0]) quarter = phase_cnt[BASE_LOG-1+r -: 2];
  end

  always_comb begin
    case (blink_ratio_e'(ratio_i))
      RATIO_SHORT: dark_o = (quarter != 2'd0);
      RATIO_LONG:  dark_o = (quarter == 2'd3);
      default:     dark_o = quarter[1];
    endcase
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vs_rise_o |=> $stable(phase_cnt)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    vs_rise_o |=> phase_cnt == $past(phase_cnt) + 1'b1); // R7
endmodule

// File: rtl/osd_attr_latch.sv
module osd_attr_latch (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_start_i,
  input  logic                dot_i,
  input  logic                active_i,
  input  osd_pkg::cell_attr_t attr_i,
  output logic                dot_q,
  output logic                act_q,
  output osd_pkg::cell_attr_t attr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q  <= 1'b0;
      act_q  <= 1'b0;
      attr_q <= '0;
    end else begin
      dot_q <= dot_i;
      act_q <= active_i;
      if (cell_start_i) attr_q <= attr_i;
    end
  end

  AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cell_start_i |=> $stable(attr_q)); // R6
endmodule

// File: rtl/osd_pixel_mux.sv
module osd_pixel_mux (
  input  logic                clk,
  input  logic                rst,
  input  logic                dot_q,
  input  logic                act_q,
  input  osd_pkg::cell_attr_t attr_q,
  input  logic                dark_i,
  input  logic                box_i,
  input  logic [3:0]          pol_i,
  output logic                r_o,
  output logic                g_o,
  output logic                b_o,
  output logic                fb_o
);
  import osd_pkg::*;
  logic             fg_on;
  logic [COL_W-1:0] rgb_raw;
  logic             fb_raw;

  always_comb begin
    fg_on   = act_q & dot_q & ~(attr_q.blink & dark_i);
    rgb_raw = '0;
    fb_raw  = 1'b0;
    if (fg_on) begin
      rgb_raw = attr_q.fg;
      fb_raw  = 1'b1;
    end else if (act_q && box_i) begin
      rgb_raw = attr_q.bg;
      fb_raw  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {r_o, g_o, b_o, fb_o} <= pol_i;
    end else begin
      {r_o, g_o, b_o, fb_o} <= {rgb_raw, fb_raw} ^ pol_i;
    end
  end

  AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !act_q |=> {r_o, g_o, b_o, fb_o} == $past(pol_i)); // R4
  AST_FG_FB: assert property (@(posedge clk) disable iff (rst)
    (act_q && dot_q && !attr_q.blink) |=> fb_o != $past(pol_i[0])); // R2
endmodule

// File: rtl/osd_color_out.sv
module osd_color_out #(
  parameter int BLINK_BASE_LOG = 4,
  parameter int RATE_STEPS     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          vsync_i,
  input  logic                          dot_i,
  input  logic                          active_i,
  input  logic                          cell_start_i,
  input  logic [2:0]                    fg_i,
  input  logic [2:0]                    bg_i,
  input  logic                          blink_i,
  input  logic                          box_mode_i,
  input  logic [$clog2(RATE_STEPS)-1:0] blink_rate_i,
  input  logic [1:0]                    blink_ratio_i,
  input  logic [3:0]                    pol_i,
  input  logic                          irq_en_i,
  input  logic                          irq_clr_i,
  output logic                          r_o,
  output logic                          g_o,
  output logic                          b_o,
  output logic                          fb_o,
  output logic                          irq_o
);
  import osd_pkg::*;

  cell_attr_t attr_in, attr_q;
  logic       dot_q, act_q, vs_rise, dark;

  assign attr_in = '{fg: fg_i, bg: bg_i, blink: blink_i};

  osd_blink_timer #(.BASE_LOG(BLINK_BASE_LOG), .RATE_STEPS(RATE_STEPS)) u_blink (
    .clk(clk), .rst(rst), .vsync_i(vsync_i), .rate_i(blink_rate_i),
    .ratio_i(blink_ratio_i), .vs_rise_o(vs_rise), .dark_o(dark));

  osd_attr_latch u_latch (
    .clk(clk), .rst(rst), .cell_start_i(cell_start_i), .dot_i(dot_i),
    .active_i(active_i), .attr_i(attr_in), .dot_q(dot_q), .act_q(act_q),
    .attr_q(attr_q));

  osd_pixel_mux u_mux (
    .clk(clk), .rst(rst), .dot_q(dot_q), .act_q(act_q), .attr_q(attr_q),
    .dark_i(dark), .box_i(box_mode_i), .pol_i(pol_i),
    .r_o(r_o), .g_o(g_o), .b_o(b_o), .fb_o(fb_o));

  always_ff @(posedge clk) begin
    if (rst)                      irq_o <= 1'b0;
    else if (vs_rise && irq_en_i) irq_o <= 1'b1;
    else if (irq_clr_i)           irq_o <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (vs_rise && irq_en_i) |=> irq_o); // R9
  AST_IRQ_NO_EN: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !irq_en_i) |=> !irq_o); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr_i) |=> irq_o); // R10
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i && !(vs_rise && irq_en_i)) |=> !irq_o); // R10
endmodule

// File: tb/osd_color_out_tb.sv
module osd_color_out_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync_i = 0, dot_i = 0, active_i = 0, cell_start_i = 0, blink_i = 0, box_mode_i = 0;
  logic [2:0] fg_i = 0, bg_i = 0;
  logic [1:0] blink_rate_i = 0, blink_ratio_i = 0;
  logic [3:0] pol_i = 0;
  logic irq_en_i = 0, irq_clr_i = 0;
  logic r_o, g_o, b_o, fb_o, irq_o;
  int checks = 0, errors = 0, vs_count = 0;
  bit done = 0;

  always #4 clk = ~clk;

  osd_color_out u_dut (
    .clk(clk), .rst(rst), .vsync_i(vsync_i), .dot_i(dot_i), .active_i(active_i),
    .cell_start_i(cell_start_i), .fg_i(fg_i), .bg_i(bg_i), .blink_i(blink_i),
    .box_mode_i(box_mode_i), .blink_rate_i(blink_rate_i), .blink_ratio_i(blink_ratio_i),
    .pol_i(pol_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
    .r_o(r_o), .g_o(g_o), .b_o(b_o), .fb_o(fb_o), .irq_o(irq_o));

  // fields: act dot cs blink box | fg(3) bg(3) pol(4) | expected {r,g,b,fb}
  localparam logic [18:0] VEC [8] = '{
    19'b1_1_1_0_0_101_010_0000_1011, // R2 fg shown
    19'b1_0_1_0_0_101_010_0000_0000, // R3 no background
    19'b1_0_1_0_1_101_110_0000_1101, // R3 box background
    19'b0_1_1_0_1_111_110_0000_0000, // R4 outside area
    19'b1_1_1_0_0_011_000_1111_1000, // R5 all inverted
    19'b0_0_1_0_0_110_000_1010_1010, // R5 partial inversion, R4
    19'b1_1_0_0_0_001_000_0000_1101, // R6 no capture, old fg 110 kept
    19'b1_1_1_1_0_010_000_0000_0101  // R8 blink char in lit phase
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic vs_pulse();
    @(negedge clk) vsync_i = 1;
    @(negedge clk) vsync_i = 0;
    vs_count++;
  endtask

  function automatic bit dark_model(int cnt, int rate, int ratio);
    int p = 16 << rate;
    int ph = cnt % p;
    if (ratio == 1) return ph >= p / 4;
    if (ratio == 2) return ph >= 3 * p / 4;
    return ph >= p / 2;
  endfunction

  task automatic blink_sweep(int rate, int ratio, int pulses);
    blink_rate_i = 2'(rate);
    blink_ratio_i = 2'(ratio);
    for (int k = 0; k < pulses; k++) begin
      vs_pulse();
      repeat (3) @(negedge clk);
      check("R7/R8 blink phase", {r_o, g_o, b_o, fb_o},
            dark_model(vs_count, rate, ratio) ? 4'b0011 : 4'b1111);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pol_i = 4'b1010;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {r_o, g_o, b_o, fb_o}, 4'b1010);
    check("R1 irq in reset", {3'b0, irq_o}, 4'b0000);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {r_o, g_o, b_o, fb_o}, 4'b1010);
    pol_i = 0;

    foreach (VEC[i]) begin
      @(negedge clk);
      {active_i, dot_i, cell_start_i, blink_i, box_mode_i, fg_i, bg_i, pol_i} = VEC[i][18:4];
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R11 vector %0d", i), {r_o, g_o, b_o, fb_o}, VEC[i][3:0]);
    end

    // R11: exact latency of two edges
    @(negedge clk);
    {active_i, dot_i, cell_start_i, blink_i, box_mode_i, fg_i, pol_i} = {5'b11100, 3'b100, 4'b0000};
    @(negedge clk);
    active_i = 0;
    check("R11 one edge later still old", {r_o, g_o, b_o, fb_o}, 4'b0101);
    @(negedge clk);
    check("R11 two edges later", {r_o, g_o, b_o, fb_o}, 4'b1001);
    @(negedge clk);
    check("R11 then outside area", {r_o, g_o, b_o, fb_o}, 4'b0000);

    // blink sweep: blinking char fg 111, box bg 001
    @(negedge clk);
    {active_i, dot_i, cell_start_i, blink_i, box_mode_i} = 5'b11110;
    fg_i = 3'b111; bg_i = 3'b001;
    @(negedge clk) cell_start_i = 0; box_mode_i = 1;
    blink_sweep(0, 0, 20);
    blink_sweep(1, 1, 40);
    blink_sweep(0, 2, 20);
    blink_sweep(3, 2, 60);
    blink_sweep(2, 3, 20);

    // R8: non-blinking char unaffected during dark phase (rate 0 ratio 1 phase nonzero)
    blink_rate_i = 0; blink_ratio_i = 1;
    while (!dark_model(vs_count, 0, 1)) vs_pulse();
    @(negedge clk) {cell_start_i, blink_i, fg_i} = {2'b10, 3'b110};
    @(negedge clk) cell_start_i = 0;
    repeat (2) @(negedge clk);
    check("R8 non-blink char in dark phase", {r_o, g_o, b_o, fb_o}, 4'b1101);

    // interrupt
    irq_en_i = 0;
    vs_pulse();
    @(negedge clk);
    check("R9 no irq when disabled", {3'b0, irq_o}, 4'b0000);
    irq_en_i = 1;
    vs_pulse();
    check("R9 irq set when enabled", {3'b0, irq_o}, 4'b0001);
    irq_en_i = 0;
    repeat (5) @(negedge clk);
    check("R10 irq held", {3'b0, irq_o}, 4'b0001);
    irq_clr_i = 1;
    @(negedge clk) irq_clr_i = 0;
    check("R10 irq cleared", {3'b0, irq_o}, 4'b0000);
    irq_en_i = 1;
    @(negedge clk) {vsync_i, irq_clr_i} = 2'b11;
    @(negedge clk) {vsync_i, irq_clr_i} = 2'b00;
    vs_count++;
    check("R10 set beats clear", {3'b0, irq_o}, 4'b0001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule